// File: doc/BRIEF.md
# Power-Down Wake-Up Controller

This block supervises the halted state of a small processor core. The core signals that it is entering power-down with a one-cycle halt strobe. The controller then drops its clock-run output and watches four kinds of wake source: an external reset request, a watchdog overflow, a newly raised interrupt request, and a falling edge on an enabled I/O pin. Pins arrive asynchronously. Each pin passes through a two-flop synchroniser before falling-edge detection, and edge detection is armed only while the core is halted.

Once a wake is accepted, the controller holds the core stopped for a fixed stabilisation delay counted in system clocks, 1024 by default. It then raises clock-run and emits a one-cycle resume strobe with an action code. The code tells the core to do one of four things: take a full reset, reset only the program counter and stack pointer, continue at the instruction after the halt, or enter the interrupt. Interrupt entry is signalled one cycle after clock-run rises. The other actions are signalled in the same cycle that clock-run rises.

An interrupt request that was already set when halt was entered cannot wake the core. When several sources arrive in the same cycle, a fixed priority chooses the action.

Top module: `pdwake_ctrl`

## Requirements
- R1: After synchronous reset, `clk_run_o` is 1 and `resume_valid_o` is 0.
- R2: A `halt_i` strobe while running makes `clk_run_o` 0 from the next cycle. The interrupt requests present in that cycle are recorded as already pending.
- R3: A wake by `ext_rst_i` while halted resumes with action code 0 (full reset).
- R4: A wake by `wdt_ovf_i` while halted resumes with action code 1 (program counter and stack pointer reset only).
- R5: A high-to-low transition on first-port pin `pa_i[j]` wakes the core only when `pa_wen_i[j]` is 1, and resumes with action code 2 (continue after halt). The pin goes through two synchroniser flops, so `clk_run_o` rises WAKE_DELAY+3 clock edges after the pin is driven low.
- R6: On the other ports, enable bit `px_wen_i[k]` covers pins `px_i[4k+3:4k]`. A falling edge on such a pin wakes the core only when the enable of its group is 1.
- R7: A wake by a newly raised request `irq_req_i[i]` with `irq_en_i[i]` = 1 and `stack_full_i` = 0 resumes with action code 3 (take interrupt). `resume_valid_o` pulses one cycle after `clk_run_o` rises.
- R8: A wake by a newly raised request whose enable is 0, or any request while `stack_full_i` = 1, resumes with action code 2. `resume_valid_o` pulses in the cycle `clk_run_o` rises.
- R9: A request that was already set at halt entry does not wake the core. A different request raised later still does.
- R10: For a source accepted directly (not a pin), `clk_run_o` stays 0 and rises exactly WAKE_DELAY+1 clock edges after the source is presented.
- R11: Sources arriving in the same cycle are prioritised as follows: external reset first, then watchdog, then interrupt, then pin.
- R12: `resume_valid_o` lasts exactly one cycle, and only while `clk_run_o` is 1.
- R13: A pin falling edge that happens while running is not remembered, so it cannot wake the core after a later halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_i | input | 1 | One-cycle strobe: the core enters power-down |
| ext_rst_i | input | 1 | External reset request |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| pa_i | input | PA_W | First-port pins (asynchronous, idle high) |
| pa_wen_i | input | PA_W | Per-pin wake enables for the first port |
| px_i | input | 4*NIB_N | Other-port pins (asynchronous, idle high) |
| px_wen_i | input | NIB_N | Per-nibble wake enables for the other ports |
| irq_req_i | input | IRQ_N | Interrupt request flags |
| irq_en_i | input | IRQ_N | Interrupt enables |
| stack_full_i | input | 1 | Call stack has no free level |
| clk_run_o | output | 1 | Core clock runs / core ready |
| resume_valid_o | output | 1 | One-cycle strobe that carries the resume action |
| resume_act_o | output | 2 | Action: 0 full reset, 1 PC/SP reset, 2 continue, 3 take interrupt |

## Verification
The bench sweeps every pin of the first port and every pin of the other ports. It pairs each pin with its own enable and with a wrong one, so an enable decoder that is off by one or that maps nibbles wrongly either misses a wake or wakes on a masked pin. It goes through every interrupt line against every combination of enable and stack-full, and through all fifteen mixes of simultaneous sources. A wrong priority order or a swapped action code therefore shows up as a wrong resume code, and a delay counter that is off by one shows up as a rise one cycle early or late. It also halts with a request already pending, and with a pin that fell while running. Either mistake would end the halt at once, where the correct design stays asleep.

// File: rtl/pdw_pkg.sv
// Package: shared types of the power-down wake-up controller.
// Assumes: action codes are decoded by the core, so their values are fixed.
package pdw_pkg;

    typedef enum logic [1:0] {
        ACT_FULL_RST = 2'd0,
        ACT_PC_RST   = 2'd1,
        ACT_CONTINUE = 2'd2,
        ACT_TAKE_IRQ = 2'd3
    } resume_act_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALT,
        ST_WAIT,
        ST_GAP,
        ST_FIRE
    } pdw_state_e;

endpackage

// File: rtl/pdw_pin_edge.sv
// Module: pdw_pin_edge
// Synchronises the wake pins, expands the per-nibble enables and flags an
// enabled falling edge. Assumes pins idle high. The previous-value register
// tracks all the time, so an edge seen while disarmed is lost.
module pdw_pin_edge #(
    parameter int PA_W  = 8,
    parameter int NIB_N = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm_i,
    input  logic [PA_W-1:0]      pa_i,
    input  logic [PA_W-1:0]      pa_wen_i,
    input  logic [4*NIB_N-1:0]   px_i,
    input  logic [NIB_N-1:0]     px_wen_i,
    output logic                 fall_o
);
    localparam int PX_W  = 4 * NIB_N;
    localparam int ALL_W = PA_W + PX_W;

    logic [ALL_W-1:0] meta_q, sync_q, prev_q, pin_en;

    // Expand each nibble enable over its four pins.
    generate
        for (genvar k = 0; k < NIB_N; k++) begin : g_nib
            assign pin_en[PA_W+4*k +: 4] = {4{px_wen_i[k]}};
        end
    endgenerate
    assign pin_en[PA_W-1:0] = pa_wen_i;

    // Two-flop synchroniser followed by the previous-value stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= {px_i, pa_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // An enabled pin that was high and is now low, counted only when armed.
    assign fall_o = arm_i && |(prev_q & ~sync_q & pin_en);

endmodule

// File: rtl/pdw_src_arb.sv
// Module: pdw_src_arb
// Combines the wake sources while halted and picks the resume action by
// fixed priority. Assumes interrupt inputs are synchronous to clk.
module pdw_src_arb
    import pdw_pkg::*;
#(
    parameter int IRQ_N = 3
) (
    input  logic              halted_i,
    input  logic              ext_rst_i,
    input  logic              wdt_ovf_i,
    input  logic [IRQ_N-1:0]  irq_req_i,
    input  logic [IRQ_N-1:0]  irq_pend_i,
    input  logic [IRQ_N-1:0]  irq_en_i,
    input  logic              stack_full_i,
    input  logic              pin_fall_i,
    output logic              wake_o,
    output resume_act_e       act_o
);
    logic [IRQ_N-1:0] fresh_irq;
    logic             irq_wake, irq_serv;

    // Only requests raised after halt entry may wake.
    assign fresh_irq = irq_req_i & ~irq_pend_i;
    assign irq_wake  = |fresh_irq;
    assign irq_serv  = (|(fresh_irq & irq_en_i)) && !stack_full_i;

    assign wake_o = halted_i && (ext_rst_i || wdt_ovf_i || irq_wake || pin_fall_i);

    // Priority: external reset, watchdog, interrupt, pin.
    always_comb begin
        if (ext_rst_i)      act_o = ACT_FULL_RST;
        else if (wdt_ovf_i) act_o = ACT_PC_RST;
        else if (irq_wake)  act_o = irq_serv ? ACT_TAKE_IRQ : ACT_CONTINUE;
        else                act_o = ACT_CONTINUE;
    end

endmodule

// File: rtl/pdw_delay.sv
// Module: pdw_delay
// Counts the stabilisation delay after a wake. done_o is high in the last
// of WAKE_DELAY busy cycles. Assumes WAKE_DELAY >= 2 and no start while busy.
module pdw_delay #(
    parameter int WAKE_DELAY = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = (WAKE_DELAY > 2) ? $clog2(WAKE_DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAKE_DELAY - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Load on start, then count until the last cycle of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
            busy_q <= (cnt_q != LAST);
        end
    end

    assign done_o = busy_q && (cnt_q == LAST);

endmodule

// File: rtl/pdwake_ctrl.sv
// Module: pdwake_ctrl (top)
// Sequences halt, wake acceptance, stabilisation delay and resume signalling.
// Assumes halt_i is only strobed while clk_run_o is 1 and no strobe comes
// in the cycle resume_valid_o is high; those strobes are ignored.
module pdwake_ctrl
    import pdw_pkg::*;
#(
    parameter int PA_W       = 8,
    parameter int NIB_N      = 2,
    parameter int IRQ_N      = 3,
    parameter int WAKE_DELAY = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_i,
    input  logic               ext_rst_i,
    input  logic               wdt_ovf_i,
    input  logic [PA_W-1:0]    pa_i,
    input  logic [PA_W-1:0]    pa_wen_i,
    input  logic [4*NIB_N-1:0] px_i,
    input  logic [NIB_N-1:0]   px_wen_i,
    input  logic [IRQ_N-1:0]   irq_req_i,
    input  logic [IRQ_N-1:0]   irq_en_i,
    input  logic               stack_full_i,
    output logic               clk_run_o,
    output logic               resume_valid_o,
    output logic [1:0]         resume_act_o
);
    pdw_state_e       state_q;
    resume_act_e      act_q, arb_act;
    logic [IRQ_N-1:0] pend_q;
    logic             halted, pin_fall, wake, delay_done;

    assign halted = (state_q == ST_HALT);

    pdw_pin_edge #(.PA_W(PA_W), .NIB_N(NIB_N)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (halted),
        .pa_i     (pa_i),
        .pa_wen_i (pa_wen_i),
        .px_i     (px_i),
        .px_wen_i (px_wen_i),
        .fall_o   (pin_fall)
    );

    pdw_src_arb #(.IRQ_N(IRQ_N)) u_arb (
        .halted_i     (halted),
        .ext_rst_i    (ext_rst_i),
        .wdt_ovf_i    (wdt_ovf_i),
        .irq_req_i    (irq_req_i),
        .irq_pend_i   (pend_q),
        .irq_en_i     (irq_en_i),
        .stack_full_i (stack_full_i),
        .pin_fall_i   (pin_fall),
        .wake_o       (wake),
        .act_o        (arb_act)
    );

    pdw_delay #(.WAKE_DELAY(WAKE_DELAY)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wake),
        .done_o  (delay_done)
    );

    // Main sequence: run -> halt -> wait -> (gap) -> fire -> run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            act_q   <= ACT_CONTINUE;
            pend_q  <= '0;
        end else begin
            case (state_q)
                ST_RUN: if (halt_i) begin
                    state_q <= ST_HALT;
                    pend_q  <= irq_req_i;
                end
                ST_HALT: if (wake) begin
                    state_q <= ST_WAIT;
                    act_q   <= arb_act;
                end
                ST_WAIT: if (delay_done) begin
                    state_q <= (act_q == ACT_TAKE_IRQ) ? ST_GAP : ST_FIRE;
                end
                ST_GAP:  state_q <= ST_FIRE;
                ST_FIRE: state_q <= ST_RUN;
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Output decode from the sequence state.
    assign clk_run_o      = (state_q == ST_RUN) || (state_q == ST_GAP) || (state_q == ST_FIRE);
    assign resume_valid_o = (state_q == ST_FIRE);
    assign resume_act_o   = act_q;

endmodule

// File: rtl/pdwake_ctrl_chk.sv
// Module: pdwake_ctrl_chk
// Protocol checker for pdwake_ctrl, attached by bind. Watches only the
// ports and measures the sleep window with its own counter.
module pdwake_ctrl_chk #(
    parameter int WAKE_DELAY = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_i,
    input logic       clk_run_o,
    input logic       resume_valid_o,
    input logic [1:0] resume_act_o
);
    int unsigned low_cnt;

    // Counts consecutive cycles with the core clock stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || clk_run_o) low_cnt <= 0;
        else if (low_cnt != 32'hFFFF_FFFF) low_cnt <= low_cnt + 1;
    end

    assert_stop_needs_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_run_o) |-> $past(halt_i));

    assert_sleep_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_run_o) |-> (low_cnt >= WAKE_DELAY));

    assert_irq_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_valid_o && resume_act_o == 2'd3) |-> $past(clk_run_o));

    assert_plain_at_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_valid_o && resume_act_o != 2'd3) |-> !$past(clk_run_o));

    assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid_o |=> !resume_valid_o);

    assert_pulse_running_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid_o |-> clk_run_o);

endmodule

bind pdwake_ctrl pdwake_ctrl_chk #(.WAKE_DELAY(WAKE_DELAY)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_i         (halt_i),
    .clk_run_o      (clk_run_o),
    .resume_valid_o (resume_valid_o),
    .resume_act_o   (resume_act_o)
);

// File: tb/pdwake_ctrl_bench.sv
module pdwake_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W  = 8;
    localparam int NIB_N = 2;
    localparam int PX_W  = 4 * NIB_N;
    localparam int IRQ_N = 3;
    localparam int DLY   = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b0, ext = 1'b0, wdt = 1'b0, sf = 1'b0;
    logic [PA_W-1:0]  pa = '1, pa_wen = '0;
    logic [PX_W-1:0]  px = '1;
    logic [NIB_N-1:0] px_wen = '0;
    logic [IRQ_N-1:0] irq_req = '0, irq_en = '0;
    logic clk_run, rvalid;
    logic [1:0] ract;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdwake_ctrl #(.PA_W(PA_W), .NIB_N(NIB_N), .IRQ_N(IRQ_N), .WAKE_DELAY(DLY)) u_pdwake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .ext_rst_i(ext), .wdt_ovf_i(wdt),
        .pa_i(pa), .pa_wen_i(pa_wen), .px_i(px), .px_wen_i(px_wen),
        .irq_req_i(irq_req), .irq_en_i(irq_en), .stack_full_i(sf),
        .clk_run_o(clk_run), .resume_valid_o(rvalid), .resume_act_o(ract)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_halt(input string req);
        @(negedge clk); halt = 1'b1;
        @(negedge clk); halt = 1'b0;
        check(clk_run == 1'b0, req, int'(clk_run), 0);
    endtask

    // Presents pin falls, waits for the synchroniser, then presents the
    // direct sources; expects a rise after DLY+1 edges measured from there.
    task automatic do_wake(input bit e, input bit w, input logic [IRQ_N-1:0] ib,
                           input logic [PA_W-1:0] paf, input logic [PX_W-1:0] pxf,
                           input bit exp_wake, input int exp_act, input string req);
        int n;
        int lim;
        @(negedge clk); pa = ~paf; px = ~pxf;
        @(negedge clk);
        @(negedge clk);
        ext = e; wdt = w; irq_req = irq_req | ib;
        lim = exp_wake ? DLY + 8 : 40;
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 1) begin ext = 1'b0; wdt = 1'b0; end
        end while (!clk_run && n < lim);
        if (!exp_wake) begin
            check(clk_run == 1'b0, {req, " no wake"}, int'(clk_run), 0);
            return;
        end
        check(n == DLY + 1, {req, " R10 delay"}, n, DLY + 1);
        if (exp_act == 3) begin
            check(rvalid == 1'b0, {req, " R7 early strobe"}, int'(rvalid), 0);
            @(negedge clk);
        end
        check(rvalid == 1'b1, {req, " strobe"}, int'(rvalid), 1);
        check(int'(ract) == exp_act, {req, " action"}, int'(ract), exp_act);
        @(negedge clk);
        check(rvalid == 1'b0, {req, " R12 single"}, int'(rvalid), 0);
        irq_req = '0; pa = '1; px = '1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_run == 1'b1, "R1 clk_run", int'(clk_run), 1);
        check(rvalid == 1'b0, "R1 strobe", int'(rvalid), 0);

        // R3, R4: single direct sources
        do_halt("R2");
        do_wake(1, 0, '0, '0, '0, 1, 0, "R3");
        do_halt("R2");
        do_wake(0, 1, '0, '0, '0, 1, 1, "R4");

        // R5: each first-port pin with its own and a wrong enable
        for (int p = 0; p < PA_W; p++) begin
            pa_wen = PA_W'(1) << p;
            do_halt("R2");
            do_wake(0, 0, '0, PA_W'(1) << ((p + 1) % PA_W), '0, 0, 2, "R5 masked pin");
            do_wake(0, 0, '0, PA_W'(1) << p, '0, 1, 2, "R5 enabled pin");
        end
        pa_wen = '0;

        // R6: each other-port pin with its group enable and the other group
        for (int j = 0; j < PX_W; j++) begin
            px_wen = NIB_N'(1) << ((j / 4 + 1) % NIB_N);
            do_halt("R2");
            do_wake(0, 0, '0, '0, PX_W'(1) << j, 0, 2, "R6 wrong nibble");
            do_wake(1, 0, '0, '0, '0, 1, 0, "R6 rescue");
            px_wen = NIB_N'(1) << (j / 4);
            do_halt("R2");
            do_wake(0, 0, '0, '0, PX_W'(1) << j, 1, 2, "R6 nibble pin");
        end
        px_wen = '0;

        // R7, R8: each interrupt line against enable and stack-full
        for (int i = 0; i < IRQ_N; i++) begin
            for (int c = 0; c < 4; c++) begin
                irq_en = c[0] ? (IRQ_N'(1) << i) : ~(IRQ_N'(1) << i);
                sf = c[1];
                do_halt("R2");
                do_wake(0, 0, IRQ_N'(1) << i, '0, '0, 1,
                        (c[0] && !c[1]) ? 3 : 2, (c[0] && !c[1]) ? "R7 irq" : "R8 irq");
            end
        end
        sf = 1'b0;

        // R9: pending request cannot wake; a fresh one can
        irq_en = '1;
        @(negedge clk); irq_req = 3'b001;
        do_halt("R2");
        do_wake(0, 0, '0, '0, '0, 0, 2, "R9 pending");
        do_wake(0, 0, 3'b010, '0, '0, 1, 3, "R9 fresh irq");
        irq_en = '0;

        // R11: all mixes of simultaneous sources
        irq_en = 3'b001;
        pa_wen = 8'h01;
        for (int m = 1; m < 16; m++) begin
            do_halt("R2");
            do_wake(m[0], m[1], m[2] ? 3'b001 : 3'b000, m[3] ? 8'h01 : 8'h00, '0, 1,
                    m[0] ? 0 : (m[1] ? 1 : (m[2] ? 3 : 2)), "R11 priority");
        end
        irq_en = '0;

        // R13: a fall while running is not remembered
        @(negedge clk); pa = 8'hFE;
        repeat (4) @(negedge clk);
        do_halt("R2");
        repeat (30) @(negedge clk);
        check(clk_run == 1'b0, "R13 stale edge", int'(clk_run), 0);
        @(negedge clk); pa = 8'hFF;
        repeat (3) @(negedge clk);
        do_wake(0, 0, '0, 8'h01, '0, 1, 2, "R13 fresh edge");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule